// File: doc/BRIEF.md
# Slotted-Window Acknowledge and Retry Controller

This block sits in a station on a shared single-line bus. Station traffic may only go out in a short high-speed window that recurs every bus cycle. The window is divided into numbered slots. An external timer marks the first slot with `win_start` and each later slot boundary with `slot_tick`. The controller holds one outgoing message of two or three bytes. It puts the message in a requested slot and then listens in the slot right after it for a one-byte acknowledge. That byte must equal the message header: the low five bits of the station address followed by a three-bit sequence number.

Collisions on the line cannot be detected, so a message counts as delivered only when that acknowledge arrives. If the acknowledge is missing or wrong, the message is resent in another slot. That slot is drawn from a 16-bit LFSR. The message is abandoned after a set number of retries.

The controller also answers frames from the master that are addressed to the station. It sends a single acknowledge byte at the next slot start, and that byte takes precedence over the station's own message. Bits are put on the line by an external byte-level serializer, which takes one byte per `tx_valid` cycle.

Top module: `slotted_retry_ctrl`

## Requirements
- R1: While reset is held and afterwards until a request arrives, `tx_valid`, `msg_pending`, `done_ok` and `fail` are low. The sequence number starts at 0.
- R2: A `send_req` while no message is held is accepted and `msg_pending` goes high on the next cycle. A `send_req` while a message is held is ignored, and the bytes later sent are those of the first request.
- R3: Slot numbering works as follows. `win_start` begins slot 0, and each `slot_tick` inside the window begins the next slot. The `slot_tick` after slot NUM_SLOTS-1 closes the window. Ticks while the window is closed are ignored. The first attempt goes in slot `send_slot`, or in slot NUM_SLOTS-2 if `send_slot` is larger.
- R4: A sent message starts on the cycle after its slot begins and uses consecutive `tx_valid` cycles. The bytes are: header {address[4:0] in bits 7:3, sequence in bits 2:0}, then `send_data[7:0]`, then `send_data[15:8]`. The third byte is sent only when `send_len3` is 1.
- R5: A success occurs when a byte equal to the header arrives on `rx_byte_valid` during the slot directly after the sending slot. On success, `done_ok` pulses for one cycle, `msg_pending` drops in the same cycle, and the sequence number advances by one modulo 8.
- R6: When the listening slot ends without a matching byte, the retry slot is computed from the LFSR state s as r = s mod (NUM_SLOTS-1). If r equals the previous slot, r+1 mod (NUM_SLOTS-1) is used instead. The LFSR then advances one step: shift right, XOR with 0xB400 if the shifted-out bit was 1. The LFSR is set to 0x8000 OR address in reset and advances only on retries.
- R7: When attempt MAX_RETRY+1 fails, the message is dropped. `fail` pulses for one cycle, `msg_pending` drops, and the sequence number stays unchanged.
- R8: A `rx_frame_done` whose `rx_frame_addr` equals `station_addr` makes the block send one byte {address[4:0], `rx_frame_seq`} at the next slot start. Frames for other addresses cause no transmission.
- R9: If an acknowledge byte is due in the slot targeted by the message, only the acknowledge is sent. The message keeps its slot and goes out in a later window.
- R10: `tx_valid` never rises except on the cycle after a slot start. No bytes appear in slots that carry neither a message nor an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| station_addr | input | ADDR_W | Station address |
| win_start | input | 1 | Pulse: window opens, slot 0 begins |
| slot_tick | input | 1 | Pulse: current slot ends |
| send_req | input | 1 | Queue a message |
| send_slot | input | SLOT_W | First-attempt slot |
| send_len3 | input | 1 | 1: three-byte message, 0: two-byte |
| send_data | input | 16 | Payload bytes, low byte first |
| rx_byte_valid | input | 1 | A byte was received from the line |
| rx_byte | input | 8 | Received byte |
| rx_frame_done | input | 1 | A checked master frame ended |
| rx_frame_addr | input | ADDR_W | Destination address of that frame |
| rx_frame_seq | input | 3 | Sequence number of that frame |
| tx_valid | output | 1 | Byte for the serializer |
| tx_byte | output | 8 | Byte value |
| msg_pending | output | 1 | A message is held |
| done_ok | output | 1 | One-cycle pulse: message acknowledged |
| fail | output | 1 | One-cycle pulse: message dropped |

## Verification
The hardest case to reach from the ports is an acknowledge that is due in exactly the slot where the held message is about to go out. To get there, the stimulus queues a message for slot 2 and then injects a master frame for this station during slot 1. The bench then checks that slot 2 carries only the one acknowledge byte, and that the message appears in slot 2 of the next window.

Retry placement is checked by a bench-side LFSR model computed by repeated subtraction. This model predicts every retry slot across several windows. Wrong-sequence bytes in the listening slot exercise the reject path.

// File: rtl/slotted_retry_pkg.sv
package slotted_retry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SEND,
    ST_AWAIT,
    ST_LISTEN
  } tx_state_t;

  localparam logic [15:0] LFSR_MASK = 16'hB400;

  // One Galois step of the retry-slot generator.
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {1'b0, s[15:1]} ^ (s[0] ? LFSR_MASK : 16'h0000);
  endfunction

  // Retry slot: state modulo span, bumped past the previous slot.
  function automatic int unsigned slot_pick(input logic [15:0] s,
                                            input int unsigned prev,
                                            input int unsigned span);
    int unsigned r;
    r = 32'(s) % span;
    if (r == prev) r = (r + 1) % span;
    return r;
  endfunction

  function automatic logic [7:0] hdr_code(input logic [4:0] id, input logic [2:0] seq);
    return {id, seq};
  endfunction

endpackage

// File: rtl/slotted_retry_slotclk.sv
module slotted_retry_slotclk #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_start,
  input  logic              slot_tick,
  output logic              slot_begin,
  output logic [SLOT_W-1:0] begin_idx,
  output logic              win_close
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  logic              open_q;
  logic [SLOT_W-1:0] idx_q;

  assign slot_begin = win_start | (slot_tick & open_q & (idx_q != LAST));
  assign begin_idx  = win_start ? '0 : idx_q + 1'b1;
  assign win_close  = ~win_start & slot_tick & open_q & (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      idx_q  <= '0;
    end else if (slot_begin) begin
      open_q <= 1'b1;
      idx_q  <= begin_idx;
    end else if (win_close) begin
      open_q <= 1'b0;
    end
  end
endmodule

// File: rtl/slotted_retry_lfsr.sv
module slotted_retry_lfsr
  import slotted_retry_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       seed,
  input  logic              adv,
  input  logic [SLOT_W-1:0] prev_slot,
  output logic [SLOT_W-1:0] pick_slot
);
  logic [15:0] st_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   st_q <= seed;
    else if (adv) st_q <= lfsr_step(st_q);
  end

  assign pick_slot = SLOT_W'(slot_pick(st_q, 32'(prev_slot), 32'(NUM_SLOTS - 1)));
endmodule

// File: rtl/slotted_retry_ackq.sv
module slotted_retry_ackq
  import slotted_retry_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic              frame_done,
  input  logic [ADDR_W-1:0] frame_addr,
  input  logic [2:0]        frame_seq,
  input  logic              take,
  output logic              pend,
  output logic [7:0]        code
);
  logic hit;
  assign hit = frame_done & (frame_addr == station_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      code <= '0;
    end else begin
      if (take) pend <= 1'b0;
      if (hit) begin
        pend <= 1'b1;
        code <= hdr_code(station_addr[4:0], frame_seq);
      end
    end
  end
endmodule

// File: rtl/slotted_retry_ctrl.sv
module slotted_retry_ctrl
  import slotted_retry_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int NUM_SLOTS = 8,
  parameter int MAX_RETRY = 3,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic              win_start,
  input  logic              slot_tick,
  input  logic              send_req,
  input  logic [SLOT_W-1:0] send_slot,
  input  logic              send_len3,
  input  logic [15:0]       send_data,
  input  logic              rx_byte_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_frame_done,
  input  logic [ADDR_W-1:0] rx_frame_addr,
  input  logic [2:0]        rx_frame_seq,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              msg_pending,
  output logic              done_ok,
  output logic              fail
);
  localparam int RC_W = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);
  localparam logic [SLOT_W-1:0] TOP_SLOT = SLOT_W'(NUM_SLOTS - 2);

  tx_state_t         state;
  logic [SLOT_W-1:0] tgt;
  logic [RC_W-1:0]   retries;
  logic [2:0]        seq;
  logic              len3_q, second_q;
  logic [15:0]       data_q;

  // Named internal events (also seen by the checker).
  logic              ev_slot_begin, ev_win_close, ev_slot_end;
  logic [SLOT_W-1:0] begin_idx;
  logic              ack_pend;
  logic [7:0]        ack_code_q;
  logic              ev_ack_sent, ev_send_start, ev_ack_hit;
  logic              ev_attempt_fail, ev_give_up, ev_retry_adv;
  logic [SLOT_W-1:0] retry_slot;
  logic [7:0]        my_hdr;

  slotted_retry_slotclk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .win_start(win_start), .slot_tick(slot_tick),
    .slot_begin(ev_slot_begin), .begin_idx(begin_idx), .win_close(ev_win_close)
  );

  slotted_retry_lfsr #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .seed(16'h8000 | 16'(station_addr)),
    .adv(ev_retry_adv), .prev_slot(tgt), .pick_slot(retry_slot)
  );

  slotted_retry_ackq #(.ADDR_W(ADDR_W)) u_ackq (
    .clk(clk), .rst_n(rst_n), .station_addr(station_addr),
    .frame_done(rx_frame_done), .frame_addr(rx_frame_addr), .frame_seq(rx_frame_seq),
    .take(ev_ack_sent), .pend(ack_pend), .code(ack_code_q)
  );

  assign my_hdr          = hdr_code(station_addr[4:0], seq);
  assign ev_slot_end     = ev_slot_begin | ev_win_close;
  assign ev_ack_sent     = ev_slot_begin & ack_pend;
  assign ev_send_start   = ev_slot_begin & (state == ST_WAIT) & (begin_idx == tgt) & ~ack_pend;
  assign ev_ack_hit      = (state == ST_LISTEN) & rx_byte_valid & (rx_byte == my_hdr);
  assign ev_attempt_fail = (state == ST_LISTEN) & ev_slot_end & ~ev_ack_hit;
  assign ev_give_up      = ev_attempt_fail & (retries == RC_W'(MAX_RETRY));
  assign ev_retry_adv    = ev_attempt_fail & ~ev_give_up;
  assign msg_pending     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tgt      <= '0;
      retries  <= '0;
      seq      <= '0;
      len3_q   <= 1'b0;
      second_q <= 1'b0;
      data_q   <= '0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
      done_ok  <= 1'b0;
      fail     <= 1'b0;
    end else begin
      done_ok  <= ev_ack_hit;
      fail     <= ev_give_up;
      tx_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (send_req) begin
          state   <= ST_WAIT;
          tgt     <= (send_slot > TOP_SLOT) ? TOP_SLOT : send_slot;
          retries <= '0;
          len3_q  <= send_len3;
          data_q  <= send_data;
        end
        ST_WAIT: if (ev_send_start) begin
          tx_valid <= 1'b1;
          tx_byte  <= my_hdr;
          second_q <= 1'b0;
          state    <= ST_SEND;
        end
        ST_SEND: begin
          tx_valid <= 1'b1;
          tx_byte  <= second_q ? data_q[15:8] : data_q[7:0];
          second_q <= 1'b1;
          if (second_q || !len3_q) state <= ST_AWAIT;
        end
        ST_AWAIT: if (ev_slot_begin) state <= ST_LISTEN;
        ST_LISTEN: begin
          if (ev_ack_hit) begin
            seq   <= seq + 3'd1;
            state <= ST_IDLE;
          end else if (ev_give_up) begin
            state <= ST_IDLE;
          end else if (ev_retry_adv) begin
            retries <= retries + 1'b1;
            tgt     <= retry_slot;
            state   <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (ev_ack_sent) begin
        tx_valid <= 1'b1;
        tx_byte  <= ack_code_q;
      end
    end
  end
endmodule

// File: rtl/slotted_retry_ctrl_chk.sv
module slotted_retry_ctrl_chk #(
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              msg_pending,
  input logic              done_ok,
  input logic              fail,
  input logic              ev_slot_begin,
  input logic              ev_send_start,
  input logic              ev_ack_sent,
  input logic              ev_retry_adv,
  input logic [SLOT_W-1:0] tgt
);
  a_r7_fail_single: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> !done_ok);
  a_r5_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && fail));
  a_r5_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msg_pending) |-> (done_ok || fail));
  a_r9_ack_first: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_sent |-> !ev_send_start);
  a_r8_ack_out: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_sent |=> tx_valid);
  a_r10_tx_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(ev_slot_begin));
  a_r6_new_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retry_adv |=> (tgt != $past(tgt)));
endmodule

bind slotted_retry_ctrl slotted_retry_ctrl_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .msg_pending(msg_pending),
  .done_ok(done_ok), .fail(fail), .ev_slot_begin(ev_slot_begin),
  .ev_send_start(ev_send_start), .ev_ack_sent(ev_ack_sent),
  .ev_retry_adv(ev_retry_adv), .tgt(tgt)
);

// File: tb/slotted_retry_ctrl_bench.sv
module slotted_retry_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 8;
  localparam int MAXR = 3;
  localparam logic [8:0] ADDR = 9'd301;
  localparam logic [4:0] ID   = ADDR[4:0];

  logic clk = 0, rst_n = 0;
  logic win_start = 0, slot_tick = 0, send_req = 0, send_len3 = 0;
  logic [2:0] send_slot = 0;
  logic [15:0] send_data = 0;
  logic rx_byte_valid = 0, rx_frame_done = 0;
  logic [7:0] rx_byte = 0;
  logic [8:0] rx_frame_addr = 0;
  logic [2:0] rx_frame_seq = 0;
  logic tx_valid, msg_pending, done_ok, fail;
  logic [7:0] tx_byte;

  always #(CLK_PERIOD/2) clk = ~clk;

  slotted_retry_ctrl u_slotted_retry_ctrl (
    .clk(clk), .rst_n(rst_n), .station_addr(ADDR), .win_start(win_start),
    .slot_tick(slot_tick), .send_req(send_req), .send_slot(send_slot),
    .send_len3(send_len3), .send_data(send_data), .rx_byte_valid(rx_byte_valid),
    .rx_byte(rx_byte), .rx_frame_done(rx_frame_done), .rx_frame_addr(rx_frame_addr),
    .rx_frame_seq(rx_frame_seq), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .msg_pending(msg_pending), .done_ok(done_ok), .fail(fail)
  );

  int checks = 0, errs = 0, ok_seen = 0, fail_seen = 0;
  bit finished = 0;

  always @(posedge clk) if (rst_n) begin
    if (done_ok) ok_seen++;
    if (fail) fail_seen++;
  end

  // Vector: {slot[23:21], len3[20], data[19:4], ack_attempt[3:1], bad[0]}
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {3'd3, 1'b0, 16'h00A5, 3'd1, 1'b0},
    {3'd0, 1'b1, 16'h3C7E, 3'd2, 1'b1},
    {3'd7, 1'b1, 16'hBEEF, 3'd3, 1'b0},
    {3'd5, 1'b0, 16'h0011, 3'd0, 1'b1},
    {3'd1, 1'b1, 16'h1234, 3'd4, 1'b0},
    {3'd6, 1'b0, 16'h0099, 3'd0, 1'b0}
  };

  // Bench model
  int m_state = 0, m_tgt = 0, m_ret = 0, m_att = 0, m_a = 0;
  bit m_bad = 0, m_len3 = 0, m_ack = 0;
  logic [15:0] m_data = 0;
  logic [15:0] m_lfsr = 16'h8000 | 16'(ADDR);
  logic [2:0] m_seq = 0;
  logic [7:0] m_ackb = 0;
  int exp_ok = 0, exp_fail = 0;

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] b_step(input logic [15:0] s);
    logic out;
    out = s[0];
    s = s >> 1;
    if (out) s = s ^ 16'hB400;
    return s;
  endfunction

  function automatic int b_pick(input logic [15:0] s, input int prev);
    int r;
    r = int'(s);
    while (r >= NS - 1) r = r - (NS - 1);
    if (r == prev) begin
      r = r + 1;
      if (r == NS - 1) r = 0;
    end
    return r;
  endfunction

  task automatic model_fail();
    if (m_ret == MAXR) begin
      m_state = 0;
      exp_fail++;
    end else begin
      m_ret++;
      m_tgt = b_pick(m_lfsr, m_tgt);
      m_lfsr = b_step(m_lfsr);
      m_state = 1;
    end
  endtask

  // One slot (or closing tick) on the wire; captures up to 4 tx bytes.
  task automatic step(input int b, input bit close, input bit frv,
                      input logic [8:0] fra, input logic [2:0] frs);
    int exp_n, nb;
    logic [7:0] eb [3];
    logic [7:0] cap [4];
    bit ackv, just_ack, listening, retry_send;
    logic [7:0] ackb, hdr;
    exp_n = 0; ackv = 0; ackb = 0; just_ack = 0; listening = 0; retry_send = 0; nb = 0;
    for (int i = 0; i < 3; i++) eb[i] = 0;
    hdr = {ID, m_seq};
    if (!close) begin
      if (m_ack) begin exp_n = 1; eb[0] = m_ackb; m_ack = 0; just_ack = 1; end
      case (m_state)
        3: model_fail();
        2: begin m_state = 3; listening = 1; end
        1: if (b == m_tgt && !just_ack) begin
             exp_n = m_len3 ? 3 : 2;
             eb[0] = hdr; eb[1] = m_data[7:0]; eb[2] = m_data[15:8];
             m_state = 2; m_att++; retry_send = (m_ret > 0);
           end
        default: ;
      endcase
      if (listening) begin
        if (m_att == m_a) begin
          ackv = 1; ackb = hdr; m_state = 0; m_seq = m_seq + 3'd1; exp_ok++;
        end else if (m_bad) begin
          ackv = 1; ackb = {ID, hdr[2:0] + 3'd1};
        end
      end
    end else if (m_state == 3) model_fail();
    if (frv && fra == ADDR) begin m_ack = 1; m_ackb = {ID, frs}; end

    @(negedge clk);
    win_start = (b == 0) && !close;
    slot_tick = !((b == 0) && !close);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      win_start = 0; slot_tick = 0;
      if (tx_valid) begin
        if (nb < 4) cap[nb] = tx_byte;
        nb++;
      end
      rx_byte_valid = (c == 4) && ackv;
      rx_byte = ackb;
      rx_frame_done = (c == 5) && frv;
      rx_frame_addr = fra;
      rx_frame_seq = frs;
    end
    rx_byte_valid = 0; rx_frame_done = 0;

    if (exp_n == 0) chk(nb == 0, "R10 quiet slot", nb, 0);
    else if (just_ack) begin
      chk(nb == 1, "R9 ack-only slot byte count", nb, 1);
      chk(nb >= 1 && cap[0] == eb[0], "R8 ack byte", int'(cap[0]), int'(eb[0]));
    end else begin
      chk(nb == exp_n, retry_send ? "R6 retry slot byte count" : "R3 send slot byte count", nb, exp_n);
      for (int i = 0; i < 3; i++)
        if (i < exp_n && i < nb) chk(cap[i] == eb[i], "R4 frame byte", int'(cap[i]), int'(eb[i]));
    end
  endtask

  task automatic run_window();
    for (int b = 0; b < NS; b++) step(b, 0, 0, 9'd0, 3'd0);
    step(0, 1, 0, 9'd0, 3'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic request(input logic [2:0] sl, input bit l3, input logic [15:0] d,
                         input int a, input bit bad);
    @(negedge clk);
    send_req = 1; send_slot = sl; send_len3 = l3; send_data = d;
    @(negedge clk);
    send_slot = 3'd4; send_len3 = ~l3; send_data = ~d;   // must be ignored (R2)
    @(negedge clk);
    send_req = 0;
    chk(msg_pending == 1'b1, "R2 pending after request", msg_pending, 1);
    m_state = 1; m_tgt = (sl > NS - 2) ? NS - 2 : int'(sl); m_ret = 0; m_att = 0;
    m_a = a; m_bad = bad; m_len3 = l3; m_data = d;
  endtask

  task automatic settle_and_check();
    for (int w = 0; w < 12 && m_state != 0; w++) run_window();
    chk(msg_pending == 1'b0, "R7 pending cleared", msg_pending, 0);
    chk(ok_seen == exp_ok, "R5 done_ok pulses", ok_seen, exp_ok);
    chk(fail_seen == exp_fail, "R7 fail pulses", fail_seen, exp_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(tx_valid == 0 && msg_pending == 0 && done_ok == 0 && fail == 0,
        "R1 outputs during reset", {tx_valid, msg_pending, done_ok, fail}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(tx_valid == 0 && msg_pending == 0, "R1 idle after reset", {tx_valid, msg_pending}, 0);

    // R3: tick with window closed and an empty window produce nothing
    step(0, 1, 0, 9'd0, 3'd0);
    run_window();

    for (int v = 0; v < NV; v++) begin
      request(VEC[v][23:21], VEC[v][20], VEC[v][19:4], int'(VEC[v][3:1]), VEC[v][0]);
      settle_and_check();
    end

    // R9 / R8: ack due in the message's own slot; foreign frame ignored
    request(3'd2, 1'b0, 16'h0042, 1, 1'b0);
    step(0, 0, 0, 9'd0, 3'd0);
    step(1, 0, 1, ADDR, 3'd5);
    step(2, 0, 0, 9'd0, 3'd0);
    step(3, 0, 1, ADDR ^ 9'd1, 3'd6);
    for (int b = 4; b < NS; b++) step(b, 0, 0, 9'd0, 3'd0);
    step(0, 1, 0, 9'd0, 3'd0);
    chk(msg_pending == 1'b1, "R9 message held after ack slot", msg_pending, 1);
    settle_and_check();

    // R8: ack queued at the closing tick goes out in next window slot 0
    step(0, 0, 0, 9'd0, 3'd0);
    for (int b = 1; b < NS; b++) step(b, 0, (b == NS - 1), ADDR, 3'd2);
    step(0, 1, 0, 9'd0, 3'd0);
    run_window();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule